// File: doc/BRIEF.md
# Multi-Lane Serial Byte Shifter

This block converts one byte from a transmit path into a stream of serial beats on a four-lane data bus. A runtime width select picks one, two or four lanes, so each beat carries one, two or four bits, and a byte takes eight, four or two beats. A second select picks the bit order: low bit first or high bit first. A per-lane output enable tells the pad logic which lanes to drive. An active-low select input gates all enables off while the link is idle.

The first beat of every byte is driven combinationally from the byte input. The block needs no preload cycle, so the lanes carry the leading bits in the same cycle the byte is offered. Later beats come from an internal shift register. That register is filled from the byte on the first beat and shifted with zero fill by the lane width on each beat that the valid strobe is high. A beat counter tracks the byte. It raises a last-beat strobe on the final beat and a near-end flag one beat earlier, so an upstream source can have the next byte ready.

Top module: `lane_serializer`

## Requirements
- R1: After reset the beat counter is at the first beat of a byte, `byte_done_o` is 0, and in single mode `near_end_o` is 0.
- R2: Width select `mode_i` encodes 0 = single, 1 = dual, 2 = quad. In single mode the bit is driven on lane 1 and lanes 3, 2 and 0 are 0. In dual mode lanes 1:0 carry the bit pair and lanes 3:2 are 0. In quad mode lanes 3:0 carry the nibble.
- R3: With `lsb_first_i` = 1, beat k carries byte bits [k*w+w-1 : k*w], where w is the lane width. The higher-numbered bit goes on the higher-numbered lane.
- R4: With `lsb_first_i` = 0, beat k carries byte bits [7-k*w : 8-(k+1)*w]. The higher-numbered bit goes on the higher-numbered lane.
- R5: On the first beat of a byte, the lanes reflect `byte_i` in the same cycle, with no register delay.
- R6: A byte lasts 8, 4 or 2 beats in single, dual or quad mode. `byte_done_o` is 1 exactly on the final beat, and the next beat starts a new byte.
- R7: `near_end_o` is 1 exactly on the beat before the final beat. In quad mode this is the first beat.
- R8: While `byte_vld_i` is 0 on a beat other than the final one, the beat position and shift register hold, and `byte_i` has no effect past the first beat. On the final beat the counter returns to the first beat even with `byte_vld_i` at 0.
- R9: With `cs_n_i` = 0, `lane_oe_o` is 4'b0010 in single mode, 4'b0011 in dual mode and 4'b1111 in quad mode. With `cs_n_i` = 1, `lane_oe_o` is 4'b0000.
- R10: The unused `mode_i` value 3 behaves exactly like single mode.
- R11: `mode_i` and `lsb_first_i` change only when the beat counter is at the first beat of a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Link select, active low; high forces all enables off |
| mode_i | input | 2 | Lane width: 0 single, 1 dual, 2 quad, 3 as single |
| lsb_first_i | input | 1 | 1 = low bit first, 0 = high bit first |
| byte_i | input | 8 | Byte to send |
| byte_vld_i | input | 1 | Advance strobe for the current beat |
| lane_o | output | 4 | Serial lane data |
| lane_oe_o | output | 4 | Per-lane output enable |
| byte_done_o | output | 1 | High on the final beat of a byte |
| near_end_o | output | 1 | High on the beat before the final beat |

## Verification
A corrupted beat counter shows within one beat. It produces a last-beat strobe in the wrong cycle, or a byte with too many or too few beats, and every following byte is then misaligned. A wrong shift direction, shift distance or fill shows on the second beat of a byte as lane data that differs from the reference order. The bench therefore compares every beat of bytes in all six width and order combinations. It also covers stalls on a middle beat and a stalled final beat, where a counter or register that fails to hold changes the lanes in the next cycle.

// File: rtl/lane_serializer.sv
module lane_serializer (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_n_i,
  input  logic [1:0] mode_i,
  input  logic       lsb_first_i,
  input  logic [7:0] byte_i,
  input  logic       byte_vld_i,
  output logic [3:0] lane_o,
  output logic [3:0] lane_oe_o,
  output logic       byte_done_o,
  output logic       near_end_o
);

  logic [2:0] cnt;
  logic [7:0] shreg;
  logic [7:0] src;
  logic [7:0] nxt;
  logic [2:0] step;
  logic [2:0] last_cnt;
  logic [2:0] pre_cnt;
  logic [3:0] oe_pat;
  logic       first_beat;

  always_comb begin
    case (mode_i)
      2'd1: begin
        step     = 3'd2;
        last_cnt = 3'd3;
        pre_cnt  = 3'd2;
        oe_pat   = 4'b0011;
      end
      2'd2: begin
        step     = 3'd4;
        last_cnt = 3'd1;
        pre_cnt  = 3'd0;
        oe_pat   = 4'b1111;
      end
      default: begin
        step     = 3'd1;
        last_cnt = 3'd7;
        pre_cnt  = 3'd6;
        oe_pat   = 4'b0010;
      end
    endcase
  end

  assign first_beat  = (cnt == 3'd0);
  assign byte_done_o = (cnt == last_cnt);
  assign near_end_o  = (cnt == pre_cnt);
  assign src         = first_beat ? byte_i : shreg;
  assign nxt         = lsb_first_i ? (src >> step) : (src << step);
  assign lane_oe_o   = cs_n_i ? 4'b0000 : oe_pat;

  always_comb begin
    case (mode_i)
      2'd1:    lane_o = lsb_first_i ? {2'b00, src[1:0]} : {2'b00, src[7:6]};
      2'd2:    lane_o = lsb_first_i ? src[3:0] : src[7:4];
      default: lane_o = {2'b00, (lsb_first_i ? src[0] : src[7]), 1'b0};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= '0;
      shreg <= '0;
    end else begin
      if (byte_done_o)     cnt <= '0;
      else if (byte_vld_i) cnt <= cnt + 3'd1;
      if (byte_vld_i)      shreg <= nxt;
    end
  end

endmodule

module lane_serializer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_n_i,
  input logic [1:0] mode_i,
  input logic       lsb_first_i,
  input logic       byte_vld_i,
  input logic [2:0] cnt,
  input logic [3:0] lane_o,
  input logic [3:0] lane_oe_o,
  input logic       byte_done_o,
  input logic       near_end_o
);

  logic [2:0] lim;
  assign lim = (mode_i == 2'd2) ? 3'd1 : (mode_i == 2'd1) ? 3'd3 : 3'd7;

  a_r11_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != 3'd0) |-> ($stable(mode_i) && $stable(lsb_first_i)));

  a_r6_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= lim);

  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |=> (cnt == 3'd0));

  a_r8_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_vld_i && !byte_done_o && cnt != 3'd0) |=> ($stable(cnt) && $stable(lane_o)));

  a_r7_near_then_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (near_end_o && byte_vld_i && !byte_done_o) |=> byte_done_o);

  a_r9_oe_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_i |-> ($countones(lane_oe_o) == 1 || $countones(lane_oe_o) == 2 ||
                 $countones(lane_oe_o) == 4));

endmodule

bind lane_serializer lane_serializer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_n_i      (cs_n_i),
  .mode_i      (mode_i),
  .lsb_first_i (lsb_first_i),
  .byte_vld_i  (byte_vld_i),
  .cnt         (cnt),
  .lane_o      (lane_o),
  .lane_oe_o   (lane_oe_o),
  .byte_done_o (byte_done_o),
  .near_end_o  (near_end_o)
);

// File: tb/test_lane_serializer.sv
module test_lane_serializer;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_n_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       lsb_first_i = 1'b1;
  logic [7:0] byte_i = 8'h00;
  logic       byte_vld_i = 1'b0;
  logic [3:0] lane_o;
  logic [3:0] lane_oe_o;
  logic       byte_done_o;
  logic       near_end_o;

  int n_chk = 0;
  int n_bad = 0;

  lane_serializer i_lane_serializer (
    .clk_i, .rst_ni, .cs_n_i, .mode_i, .lsb_first_i, .byte_i, .byte_vld_i,
    .lane_o, .lane_oe_o, .byte_done_o, .near_end_o
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int width_of(logic [1:0] m);
    return (m == 2'd2) ? 4 : (m == 2'd1) ? 2 : 1;
  endfunction

  function automatic logic [3:0] exp_lanes(logic [1:0] m, logic lsb, logic [7:0] b, int beat);
    int w = width_of(m);
    logic [7:0] ch;
    if (lsb) ch = b >> (beat * w);
    else     ch = b >> (8 - w * (beat + 1));
    ch = ch & 8'((1 << w) - 1);
    if (w == 1) return {2'b00, ch[0], 1'b0};
    return ch[3:0];
  endfunction

  function automatic logic [3:0] exp_oe(logic [1:0] m);
    return (m == 2'd2) ? 4'b1111 : (m == 2'd1) ? 4'b0011 : 4'b0010;
  endfunction

  // one full byte, valid held high; checks R2..R7, R9
  task automatic send_byte(logic [1:0] m, logic lsb, logic [7:0] b, string req);
    int nb = 8 / width_of(m);
    for (int k = 0; k < nb; k++) begin
      @(negedge clk_i);
      mode_i = m; lsb_first_i = lsb; byte_i = b; byte_vld_i = 1'b1;
      #1;
      chk(req, "lanes", 8'(lane_o), 8'(exp_lanes(m, lsb, b, k)));
      chk("R6", "done", 8'(byte_done_o), 8'(k == nb - 1));
      chk("R7", "near_end", 8'(near_end_o), 8'(k == nb - 2 || (nb == 2 && k == 0)));
      if (!cs_n_i) chk("R9", "oe", 8'(lane_oe_o), 8'(exp_oe(m)));
      else         chk("R9", "oe_idle", 8'(lane_oe_o), 8'h00);
    end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    mode_i = 2'd0; lsb_first_i = 1'b1; byte_i = 8'h01; byte_vld_i = 1'b0;
    #1;
    chk("R1", "done", 8'(byte_done_o), 8'h00);
    chk("R1", "near_end", 8'(near_end_o), 8'h00);
    chk("R5", "first_lanes", 8'(lane_o), 8'h02);
    chk("R9", "oe", 8'(lane_oe_o), 8'h02);
    byte_i = 8'h00;
    #1;
    chk("R5", "first_lanes_follow", 8'(lane_o), 8'h00);
  endtask

  task automatic t_all_modes();
    send_byte(2'd0, 1'b1, 8'hB4, "R3");
    send_byte(2'd0, 1'b0, 8'hB4, "R4");
    send_byte(2'd1, 1'b1, 8'h6C, "R3");
    send_byte(2'd1, 1'b0, 8'h6C, "R4");
    send_byte(2'd2, 1'b1, 8'hA7, "R3");
    send_byte(2'd2, 1'b0, 8'hA7, "R4");
    send_byte(2'd2, 1'b0, 8'h5E, "R2");
    send_byte(2'd1, 1'b1, 8'hF0, "R2");
    send_byte(2'd0, 1'b0, 8'h81, "R2");
  endtask

  // R8: stall on middle beat, byte_i ignored
  task automatic t_stall();
    for (int k = 0; k < 2; k++) begin
      @(negedge clk_i);
      mode_i = 2'd1; lsb_first_i = 1'b0; byte_i = 8'hB4; byte_vld_i = 1'b1;
    end
    for (int s = 0; s < 3; s++) begin
      @(negedge clk_i);
      byte_vld_i = 1'b0; byte_i = 8'h00;
      #1;
      chk("R8", "stall_lanes", 8'(lane_o), 8'(exp_lanes(2'd1, 1'b0, 8'hB4, 2)));
      chk("R8", "stall_done", 8'(byte_done_o), 8'h00);
      chk("R8", "stall_near", 8'(near_end_o), 8'h01);
    end
    for (int k = 2; k < 4; k++) begin
      @(negedge clk_i);
      byte_vld_i = 1'b1;
      #1;
      chk("R8", "resume_lanes", 8'(lane_o), 8'(exp_lanes(2'd1, 1'b0, 8'hB4, k)));
    end
  endtask

  // R8: final beat with valid low still returns to first beat
  task automatic t_last_idle();
    @(negedge clk_i);
    mode_i = 2'd2; lsb_first_i = 1'b1; byte_i = 8'h3C; byte_vld_i = 1'b1;
    @(negedge clk_i);
    byte_vld_i = 1'b0;
    #1;
    chk("R8", "idle_last_done", 8'(byte_done_o), 8'h01);
    chk("R8", "idle_last_lanes", 8'(lane_o), 8'h03);
    @(negedge clk_i);
    byte_i = 8'h9D;
    #1;
    chk("R8", "wrapped_done", 8'(byte_done_o), 8'h00);
    chk("R5", "new_first", 8'(lane_o), 8'h0D);
    send_byte(2'd2, 1'b1, 8'h9D, "R5");
  endtask

  task automatic t_cs_idle();
    cs_n_i = 1'b1;
    send_byte(2'd2, 1'b0, 8'h42, "R9");
    send_byte(2'd0, 1'b1, 8'h42, "R9");
    cs_n_i = 1'b0;
    @(negedge clk_i);
    mode_i = 2'd1; byte_vld_i = 1'b0;
    #1;
    chk("R9", "oe_back", 8'(lane_oe_o), 8'h03);
  endtask

  task automatic t_mode3();
    int errs = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      mode_i = 2'd3; lsb_first_i = 1'b1; byte_i = 8'hC9; byte_vld_i = 1'b1;
      #1;
      chk("R10", "lanes", 8'(lane_o), 8'(exp_lanes(2'd0, 1'b1, 8'hC9, k)));
      chk("R10", "done", 8'(byte_done_o), 8'(k == 7));
      chk("R10", "oe", 8'(lane_oe_o), 8'h02);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_all_modes();
    t_stall();
    t_last_idle();
    t_cs_idle();
    t_mode3();
    @(negedge clk_i);
    byte_vld_i = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule